// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block holds the page-select context for a banked register file. The visible output is the active page number. It chooses which bank of special function registers the core addresses. Two older page values sit underneath the active page, so there are three levels in total.

When the core takes an interrupt, it pulses an entry strobe together with the source ID. In the same clock edge the block does three things:
- It loads the active page from a per-source page table.
- It shifts the older values down one level.
- It drops whatever was at the bottom.

A return strobe reverses the shift. A nested interrupt arriving inside a handler therefore leaves all three contexts on the stack.

Software can read and write any level through a small select/data port. Interrupt entry and return can be held off with an enable input.

Top module: `pgstk_top`

## Requirements
- R1: After reset, all three levels (active, next, last) read 0x00 and `page_out` is 0x00.
- R2: With `en` high and `irq_take` high, on the clock edge the active level takes the page table entry for `irq_src`. The next level takes the old active value, and the last level takes the old next value. The old last value is discarded.
- R3: With `en` high, `irq_ret` high and `irq_take` low, on the clock edge the active level takes the old next value and the next level takes the old last value. The last level keeps its value.
- R4: With `en` low, `irq_take` and `irq_ret` leave all three levels unchanged. Software writes still act.
- R5: A software write (`sw_we` high) with `sw_sel` 0, 1 or 2 loads `sw_wdata` into the active, next or last level on the clock edge. A write with `sw_sel` 3 changes nothing.
- R6: When a push or pop acts in a cycle, a software write in that same cycle is ignored.
- R7: When `irq_take` and `irq_ret` are high in the same cycle with `en` high, the push is performed and the return is ignored.
- R8: `sw_rdata` shows the level chosen by `sw_sel` in the same cycle: 0 for active, 1 for next, 2 for last. Code 3 reads 0x00.
- R9: `page_out` always equals the active level.
- R10: The default page table maps source IDs 0 to 7 to pages 0x00, 0x0C, 0x12, 0x0F, 0x21, 0x3C, 0x5A and 0x7E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Allows interrupt entry and return to change the stack |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_src | input | 3 | Source ID of the interrupt being taken |
| irq_ret | input | 1 | Interrupt return strobe |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Software level select: 0 active, 1 next, 2 last |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Selected level, combinational |
| page_out | output | 8 | Active page number |

## Verification
Every push, pop or software write is registered once. Its effect on `page_out` and on the levels is due at the first rising edge after the stimulus is driven. `sw_rdata` follows `sw_sel` with no clock delay, so a read of a level reflects the state after that same edge.

The driver applies each stimulus at a falling edge and queues one expected pair per cycle. The monitor compares that pair one time unit after the next rising edge, so each value is sampled exactly where it becomes due.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
  localparam int LEVELS = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/pgstk_ctrl.sv
module pgstk_ctrl
  import pgstk_pkg::*;
(
  input  logic                    en,
  input  logic                    irq_take,
  input  logic                    irq_ret,
  input  logic                    sw_we,
  input  logic [SEL_W-1:0]        sw_sel,
  output stk_op_e                 op,
  output logic [LEVELS-1:0]       wr_en
);
  // Interrupt entry wins over return; both are gated by en.
  always_comb begin
    if (en && irq_take)     op = OP_PUSH;
    else if (en && irq_ret) op = OP_POP;
    else                    op = OP_NONE;
  end

  // Software writes only land in cycles with no stack motion.
  always_comb begin
    for (int i = 0; i < LEVELS; i++) begin
      wr_en[i] = sw_we && (op == OP_NONE) && (sw_sel == SEL_W'(i));
    end
  end
endmodule

// File: rtl/pgstk_map.sv
module pgstk_map #(
  parameter int PAGE_W = 8,
  parameter int SRC_W  = 3,
  parameter logic [(1<<SRC_W)-1:0][PAGE_W-1:0] PAGE_MAP = '0
) (
  input  logic [SRC_W-1:0]  src,
  output logic [PAGE_W-1:0] page
);
  assign page = PAGE_MAP[src];
endmodule

// File: rtl/pgstk_level.sv
module pgstk_level
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [PAGE_W-1:0] push_val,
  input  logic [PAGE_W-1:0] pop_val,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] q
);
  logic [PAGE_W-1:0] d;
  logic              ld;

  always_comb begin
    d  = q;
    ld = 1'b0;
    unique case (op)
      OP_PUSH: begin d = push_val; ld = 1'b1; end
      OP_POP:  begin d = pop_val;  ld = 1'b1; end
      default: begin
        if (wr_en) begin
          d  = wr_data;
          ld = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/pgstk_top.sv
module pgstk_top
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int SRC_W  = 3,
  parameter logic [(1<<SRC_W)-1:0][PAGE_W-1:0] PAGE_MAP =
    {8'h7E, 8'h5A, 8'h3C, 8'h21, 8'h0F, 8'h12, 8'h0C, 8'h00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              irq_take,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic              irq_ret,
  input  logic              sw_we,
  input  logic [SEL_W-1:0]  sw_sel,
  input  logic [PAGE_W-1:0] sw_wdata,
  output logic [PAGE_W-1:0] sw_rdata,
  output logic [PAGE_W-1:0] page_out
);
  // Reset synchronizer: asserts at once, releases after two edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  stk_op_e                       op;
  logic [LEVELS-1:0]             wr_en;
  logic [PAGE_W-1:0]             map_page;
  logic [LEVELS-1:0][PAGE_W-1:0] lvl_q;

  pgstk_ctrl u_ctrl (
    .en       (en),
    .irq_take (irq_take),
    .irq_ret  (irq_ret),
    .sw_we    (sw_we),
    .sw_sel   (sw_sel),
    .op       (op),
    .wr_en    (wr_en)
  );

  pgstk_map #(.PAGE_W(PAGE_W), .SRC_W(SRC_W), .PAGE_MAP(PAGE_MAP)) u_map (
    .src  (irq_src),
    .page (map_page)
  );

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    logic [PAGE_W-1:0] push_v;
    logic [PAGE_W-1:0] pop_v;

    if (i == 0) begin : g_top
      assign push_v = map_page;
    end else begin : g_below
      assign push_v = lvl_q[i-1];
    end

    if (i == LEVELS-1) begin : g_bottom
      assign pop_v = lvl_q[i];
    end else begin : g_above
      assign pop_v = lvl_q[i+1];
    end

    pgstk_level #(.PAGE_W(PAGE_W)) u_level (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .op       (op),
      .push_val (push_v),
      .pop_val  (pop_v),
      .wr_en    (wr_en[i]),
      .wr_data  (sw_wdata),
      .q        (lvl_q[i])
    );
  end

  always_comb begin
    sw_rdata = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (sw_sel == SEL_W'(i)) sw_rdata = lvl_q[i];
    end
  end

  assign page_out = lvl_q[0];
endmodule

// File: rtl/pgstk_chk.sv
module pgstk_chk
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int SRC_W  = 3,
  parameter logic [(1<<SRC_W)-1:0][PAGE_W-1:0] PAGE_MAP = '0
) (
  input logic                          clk,
  input logic                          rst_sync_n,
  input logic                          en,
  input logic                          irq_take,
  input logic [SRC_W-1:0]              irq_src,
  input logic                          irq_ret,
  input logic                          sw_we,
  input logic [SEL_W-1:0]              sw_sel,
  input logic [PAGE_W-1:0]             sw_rdata,
  input logic [PAGE_W-1:0]             page_out,
  input logic [LEVELS-1:0][PAGE_W-1:0] lvl_q
);
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && irq_take |=> page_out == PAGE_MAP[$past(irq_src)]); // R2

  AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && irq_take |=> lvl_q[1] == $past(page_out) && lvl_q[2] == $past(lvl_q[1])); // R2

  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && !irq_take && irq_ret |=> page_out == $past(lvl_q[1]) && lvl_q[1] == $past(lvl_q[2]) && $stable(lvl_q[2])); // R3

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en && !sw_we |=> $stable(lvl_q)); // R4

  AST_SEL3_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en && !irq_take && !irq_ret && sw_sel == 2'd3 |=> $stable(lvl_q)); // R5

  AST_SEL3_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_sel == 2'd3 |-> sw_rdata == '0); // R8
endmodule

bind pgstk_top pgstk_chk #(.PAGE_W(PAGE_W), .SRC_W(SRC_W), .PAGE_MAP(PAGE_MAP)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .en         (en),
  .irq_take   (irq_take),
  .irq_src    (irq_src),
  .irq_ret    (irq_ret),
  .sw_we      (sw_we),
  .sw_sel     (sw_sel),
  .sw_rdata   (sw_rdata),
  .page_out   (page_out),
  .lvl_q      (lvl_q)
);

// File: tb/pgstk_top_tb.sv
module pgstk_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, irq_take, irq_ret, sw_we;
  logic [2:0] irq_src;
  logic [1:0] sw_sel;
  logic [7:0] sw_wdata, sw_rdata, page_out;

  always #2.5 clk = ~clk;

  pgstk_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .irq_take(irq_take), .irq_src(irq_src),
    .irq_ret(irq_ret), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .page_out(page_out)
  );

  typedef struct {
    logic [7:0] page;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] m [3];
  int         n_chk = 0;
  int         n_err = 0;
  int         cyc   = 0;
  bit         done  = 1'b0;

  // R10 table, written independently of the design.
  function automatic logic [7:0] tbl(input logic [2:0] s);
    case (s)
      3'd0: return 8'h00;  3'd1: return 8'h0C;
      3'd2: return 8'h12;  3'd3: return 8'h0F;
      3'd4: return 8'h21;  3'd5: return 8'h3C;
      3'd6: return 8'h5A;  default: return 8'h7E;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, update the model, queue the expected pair.
  task automatic step(input bit e, input bit tk, input logic [2:0] s, input bit rt,
                      input bit we, input logic [1:0] sel, input logic [7:0] wd,
                      input string tag);
    exp_t x;
    @(negedge clk);
    en = e; irq_take = tk; irq_src = s; irq_ret = rt;
    sw_we = we; sw_sel = sel; sw_wdata = wd;
    if (e && tk) begin
      m[2] = m[1]; m[1] = m[0]; m[0] = tbl(s);
    end else if (e && rt) begin
      m[0] = m[1]; m[1] = m[2];
    end else if (we && sel != 2'd3) begin
      m[sel] = wd;
    end
    x.page = m[0];
    x.rd   = (sel == 2'd3) ? 8'h00 : m[sel];
    x.tag  = tag;
    sb.push_back(x);
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    step(1, 0, 0, 0, 0, sel, 8'h00, tag);
  endtask

  // Monitor: results are due one edge after the drive; sample just after it.
  always @(posedge clk) begin
    #1;
    cyc++;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_chk++;
      if (page_out !== x.page) begin
        n_err++;
        $display("FAIL %s R9 page_out actual=%h expected=%h", x.tag, page_out, x.page);
      end
      n_chk++;
      if (sw_rdata !== x.rd) begin
        n_err++;
        $display("FAIL %s R8 sw_rdata actual=%h expected=%h", x.tag, sw_rdata, x.rd);
      end
    end
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 0; irq_take = 0; irq_src = 0; irq_ret = 0;
    sw_we = 0; sw_sel = 0; sw_wdata = 0;
    m[0] = 0; m[1] = 0; m[2] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(0, "R1 reset active"); rd(1, "R1 reset next"); rd(2, "R1 reset last");

    step(1, 0, 0, 0, 1, 2, 8'h55, "R5 write last");
    step(1, 0, 0, 0, 1, 1, 8'h33, "R5 write next");
    step(1, 0, 0, 0, 1, 0, 8'hA1, "R5 write active");
    step(1, 0, 0, 0, 1, 3, 8'h99, "R5 R8 write sel3 ignored");
    rd(0, "R5 after sel3 active"); rd(1, "R5 after sel3 next"); rd(2, "R5 after sel3 last");

    step(1, 1, 1, 0, 0, 1, 8'h00, "R2 R10 push src1");
    rd(2, "R2 last dropped");
    step(1, 1, 0, 0, 0, 2, 8'h00, "R2 nested push src0");
    rd(1, "R2 nested next");
    step(1, 1, 5, 0, 1, 0, 8'hEE, "R6 push beats sw write");
    rd(1, "R6 after push next");
    step(1, 0, 0, 1, 0, 2, 8'h00, "R3 pop keeps last");
    step(1, 0, 0, 1, 1, 1, 8'h77, "R6 pop beats sw write");
    rd(1, "R3 R6 next after pop");
    step(1, 1, 7, 1, 0, 1, 8'h00, "R7 take and ret together");
    rd(2, "R7 last");

    step(0, 1, 3, 0, 0, 0, 8'h00, "R4 disabled take");
    step(0, 0, 0, 1, 0, 1, 8'h00, "R4 disabled ret");
    rd(2, "R4 last unchanged");
    step(0, 0, 0, 0, 1, 0, 8'h44, "R4 sw write while disabled");

    for (int s = 0; s < 8; s++) step(1, 1, 3'(s), 0, 0, 1, 8'h00, "R10 table sweep");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 1, 0, 2, 8'h00, "R3 pop sweep");
    rd(0, "R9 final active");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule